// File: doc/BRIEF.md
# Programmable Keypad Matrix Scanner

This block scans a key matrix of up to 16 rows by 16 columns. Keys are active low. In scan modes it pulls one row low at a time and leaves the other rows high. It waits a programmable settling time, then samples the column lines and stores one 16-bit word for that row. Software selects one of four modes: idle, any-key detect, single scan and continuous scan. It sets the row delay, the inter-scan gap, and how many rows and columns take part. A 3-bit status register with a matching mask drives one interrupt line.

Software uses a simple word-addressed register port. The port has a control word at 0x00, a limits word at 0x04, status at 0x08 and mask at 0x0C. Row data sits from 0x10 onward, two rows per word. The even row is in the low half. In any-key mode every row is driven low, and any closed key in an enabled column raises the key flag. In single-scan mode the mode field drops back to idle by itself after one pass. Continuous mode starts again after the gap.

Top module: `kp_scanner`

## Requirements
- R1: After reset the control word, status and mask read 0 and the interrupt output is 0. Every row line is high, and every data word reads 0xFFFFFFFF.
- R2: With control bits 1:0 = 0 (idle), all row lines stay high, and closed keys leave the data words unchanged.
- R3: With mode 1 (any-key), all row lines are low and the data words are not updated. A closed key in an enabled column sets status bit 2. Writing 1 to bit 2 does not clear it while the key stays closed. It clears once the key is released and bit 2 is acknowledged.
- R4: Mode 2 scans rows 0 to rows-1 once and sets status bit 0. The mode field (control bits 1:0) then reads 0 without any write.
- R5: Mode 3 keeps scanning, the mode field stays 3, and a key change appears in the data without any further write.
- R6: During a scan at most one row line is low. Each row stays low for row_delay+1 cycles, where row_delay is control bits 15:2, and it is sampled in its last cycle.
- R7: In mode 3 all rows stay high for gap+1 cycles between scans, where gap is control bits 31:16.
- R8: Rows at or above the row count (limits bits 7:0) keep their previous stored value.
- R9: In a stored row word, column bits at or above the column count (limits bits 15:8) are written as 1.
- R10: Status bit 1 is set only when a captured row word differs from the stored word.
- R11: Writing 1 bits to 0x08 clears those status bits. The interrupt output is 1 exactly when some status bit and the matching mask bit (0x0C bits 2:0) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| row_drive_n | output | NROW | Row lines, low = driven |
| col_in_n | input | NCOL | Column lines, low = key closed on a driven row |
| irq | output | 1 | Masked interrupt |

## Verification
Two events can fall in the same cycle on status bit 2: the level set from a held key in any-key mode and a software write-one acknowledge. The bench holds a key closed, writes the acknowledge, and expects bit 2 to still read 1. Only after release and a second acknowledge must it read 0. The same set-over-clear rule applies to scan completion. A checker property states that the cycle after a completion always shows bit 0 set, whatever was written.

// File: rtl/kp_pkg.sv
package kp_pkg;
  typedef enum logic [1:0] {
    KM_IDLE = 2'd0,
    KM_ANY  = 2'd1,
    KM_ONCE = 2'd2,
    KM_LOOP = 2'd3
  } kp_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_GAP    = 2'd2
  } kp_seq_e;

  localparam int ROW_DLY_W = 14;
  localparam int GAP_DLY_W = 16;
  localparam int CNT_W     = 16;
  localparam int WORD_W    = 16;
endpackage

// File: rtl/kp_scan_seq.sv
module kp_scan_seq
  import kp_pkg::*;
#(
  parameter int NROW = 16,
  parameter int NCOL = 16,
  localparam int RIW = $clog2(NROW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  kp_mode_e             mode,
  input  logic [ROW_DLY_W-1:0] row_dly,
  input  logic [GAP_DLY_W-1:0] gap_dly,
  input  logic [7:0]           row_cnt,
  input  logic [7:0]           col_cnt,
  input  logic [NCOL-1:0]      col_in_n,
  output logic [NROW-1:0]      row_drive_n,
  output logic                 cap_en,
  output logic [RIW-1:0]       cap_row,
  output logic [WORD_W-1:0]    cap_word,
  output logic                 scan_done,
  output logic                 any_key
);
  kp_seq_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       idx_q, idx_d;
  logic [7:0]       eff_rows;
  logic             last_row, scan_mode, start;
  logic [NCOL-1:0]  col_valid;

  assign eff_rows  = (row_cnt > 8'(NROW)) ? 8'(NROW) : row_cnt;
  assign last_row  = (idx_q == eff_rows - 8'd1);
  assign scan_mode = (mode == KM_ONCE) || (mode == KM_LOOP);
  assign cap_row   = idx_q[RIW-1:0];

  for (genvar c = 0; c < NCOL; c++) begin : g_colv
    assign col_valid[c] = (col_cnt > 8'(c));
  end

  for (genvar c = 0; c < WORD_W; c++) begin : g_word
    if (c < NCOL) begin : g_live
      assign cap_word[c] = col_valid[c] ? col_in_n[c] : 1'b1;
    end else begin : g_pad
      assign cap_word[c] = 1'b1;
    end
  end

  assign any_key = (mode == KM_ANY) && (|(~col_in_n & col_valid));

  for (genvar r = 0; r < NROW; r++) begin : g_row
    assign row_drive_n[r] = (mode == KM_ANY) ? 1'b0 :
                            !(st_q == SQ_SETTLE && scan_mode && idx_q == 8'(r));
  end

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    cap_en    = 1'b0;
    scan_done = 1'b0;
    start     = 1'b0;
    case (st_q)
      SQ_IDLE: if (scan_mode) start = 1'b1;
      SQ_SETTLE: begin
        if (!scan_mode) begin
          st_d = SQ_IDLE;
        end else if (cnt_q == '0) begin
          cap_en = 1'b1;
          if (last_row) begin
            scan_done = 1'b1;
            st_d      = (mode == KM_LOOP) ? SQ_GAP : SQ_IDLE;
            cnt_d     = CNT_W'(gap_dly);
          end else begin
            idx_d = idx_q + 8'd1;
            cnt_d = CNT_W'(row_dly);
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_GAP: begin
        if (mode != KM_LOOP)      st_d  = SQ_IDLE;
        else if (cnt_q == '0)     start = 1'b1;
        else                      cnt_d = cnt_q - 1'b1;
      end
      default: st_d = SQ_IDLE;
    endcase
    if (start) begin
      if (eff_rows == 8'd0) begin
        scan_done = 1'b1;
        st_d      = (mode == KM_LOOP) ? SQ_GAP : SQ_IDLE;
        cnt_d     = CNT_W'(gap_dly);
      end else begin
        st_d  = SQ_SETTLE;
        idx_d = 8'd0;
        cnt_d = CNT_W'(row_dly);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/kp_row_store.sv
module kp_row_store
  import kp_pkg::*;
#(
  parameter int NROW = 16,
  localparam int RIW = $clog2(NROW)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_en,
  input  logic [RIW-1:0]           cap_row,
  input  logic [WORD_W-1:0]        cap_word,
  output logic [NROW*WORD_W-1:0]   rows_flat,
  output logic                     row_changed
);
  logic [WORD_W-1:0] row_q [NROW];

  assign row_changed = cap_en && (cap_word != row_q[cap_row]);

  for (genvar r = 0; r < NROW; r++) begin : g_row
    logic row_we;
    assign row_we = cap_en && (cap_row == RIW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q[r] <= '1;
      else if (row_we) row_q[r] <= cap_word;
    end
    assign rows_flat[r*WORD_W +: WORD_W] = row_q[r];
  end
endmodule

// File: rtl/kp_irq_status.sv
module kp_irq_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] set_evt,
  input  logic       ack_we,
  input  logic [2:0] ack_bits,
  input  logic       mask_we,
  input  logic [2:0] mask_wd,
  output logic [2:0] sts_q,
  output logic [2:0] mask_q,
  output logic       irq
);
  logic [2:0] sts_d, clr;

  assign clr   = ack_we ? ack_bits : 3'b000;
  assign sts_d = set_evt | (sts_q & ~clr);
  assign irq   = |(sts_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wd;
  end
endmodule

// File: rtl/kp_scanner.sv
module kp_scanner
  import kp_pkg::*;
#(
  parameter int NROW   = 16,
  parameter int NCOL   = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NROW-1:0]   row_drive_n,
  input  logic [NCOL-1:0]   col_in_n,
  output logic              irq
);
  localparam int RIW   = $clog2(NROW);
  localparam int NWORD = (NROW + 1) / 2;

  kp_mode_e             mode_q, mode_d;
  logic [ROW_DLY_W-1:0] rdly_q;
  logic [GAP_DLY_W-1:0] gdly_q;
  logic [7:0]           nrow_q, ncol_q;
  logic                 in_ctl, ctrl_we, lim_we, ack_we, mask_we;
  logic                 cap_en, scan_done, any_key, row_changed;
  logic [RIW-1:0]       cap_row;
  logic [WORD_W-1:0]    cap_word;
  logic [NROW*WORD_W-1:0] rows_flat;
  logic [2:0]           sts, mask;
  logic [ADDR_W-1:0]    doff;
  logic [ADDR_W-3:0]    widx;
  logic [WORD_W-1:0]    rows_pad [2*NWORD];

  assign in_ctl  = (reg_addr[ADDR_W-1:4] == '0);
  assign ctrl_we = reg_wr && in_ctl && (reg_addr[3:2] == 2'd0);
  assign lim_we  = reg_wr && in_ctl && (reg_addr[3:2] == 2'd1);
  assign ack_we  = reg_wr && in_ctl && (reg_addr[3:2] == 2'd2);
  assign mask_we = reg_wr && in_ctl && (reg_addr[3:2] == 2'd3);

  always_comb begin
    mode_d = mode_q;
    if (ctrl_we)                              mode_d = kp_mode_e'(reg_wdata[1:0]);
    else if (scan_done && mode_q == KM_ONCE)  mode_d = KM_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= KM_IDLE;
    else        mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdly_q <= '0;
      gdly_q <= '0;
    end else if (ctrl_we) begin
      rdly_q <= reg_wdata[2 +: ROW_DLY_W];
      gdly_q <= reg_wdata[16 +: GAP_DLY_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrow_q <= 8'(NROW);
      ncol_q <= 8'(NCOL);
    end else if (lim_we) begin
      nrow_q <= reg_wdata[7:0];
      ncol_q <= reg_wdata[15:8];
    end
  end

  kp_scan_seq #(.NROW(NROW), .NCOL(NCOL)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .row_dly(rdly_q), .gap_dly(gdly_q),
    .row_cnt(nrow_q), .col_cnt(ncol_q), .col_in_n(col_in_n),
    .row_drive_n(row_drive_n), .cap_en(cap_en), .cap_row(cap_row),
    .cap_word(cap_word), .scan_done(scan_done), .any_key(any_key)
  );

  kp_row_store #(.NROW(NROW)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_row(cap_row),
    .cap_word(cap_word), .rows_flat(rows_flat), .row_changed(row_changed)
  );

  kp_irq_status u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_evt({any_key, row_changed, scan_done}),
    .ack_we(ack_we), .ack_bits(reg_wdata[2:0]),
    .mask_we(mask_we), .mask_wd(reg_wdata[2:0]),
    .sts_q(sts), .mask_q(mask), .irq(irq)
  );

  for (genvar i = 0; i < 2*NWORD; i++) begin : g_pad
    if (i < NROW) begin : g_live
      assign rows_pad[i] = rows_flat[i*WORD_W +: WORD_W];
    end else begin : g_fill
      assign rows_pad[i] = '1;
    end
  end

  assign doff = reg_addr - ADDR_W'(16);
  assign widx = doff[ADDR_W-1:2];

  always_comb begin
    reg_rdata = '0;
    if (in_ctl) begin
      case (reg_addr[3:2])
        2'd0:    reg_rdata = {gdly_q, rdly_q, mode_q};
        2'd1:    reg_rdata = {16'd0, ncol_q, nrow_q};
        2'd2:    reg_rdata = {29'd0, sts};
        default: reg_rdata = {29'd0, mask};
      endcase
    end else begin
      for (int k = 0; k < NWORD; k++) begin
        if (widx == (ADDR_W-2)'(k)) reg_rdata = {rows_pad[2*k+1], rows_pad[2*k]};
      end
    end
  end
endmodule

// File: rtl/kp_scan_chk.sv
module kp_scan_chk #(
  parameter int NROW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode,
  input logic            ctrl_we,
  input logic [NROW-1:0] row_drive_n,
  input logic            scan_done,
  input logic            any_key,
  input logic            row_changed,
  input logic [2:0]      sts
);
  AST_IDLE_ROWS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (&row_drive_n)); // R2
  AST_ANY_ROWS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> !(|row_drive_n)); // R3
  AST_KEY_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    any_key |=> sts[2]); // R3
  AST_ONCE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && mode == 2'd2 && !ctrl_we) |=> (mode == 2'd0)); // R4
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> sts[0]); // R4
  AST_ONE_ROW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> $onehot0(~row_drive_n)); // R6
  AST_CHANGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts[1] && !row_changed) |=> !sts[1]); // R10
endmodule

bind kp_scanner kp_scan_chk #(.NROW(NROW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_q), .ctrl_we(ctrl_we),
  .row_drive_n(row_drive_n), .scan_done(scan_done), .any_key(any_key),
  .row_changed(row_changed), .sts(sts)
);

// File: tb/sim_kp_scanner.sv
module sim_kp_scanner;
  localparam int NROW = 16;
  localparam int NCOL = 16;

  typedef struct {
    int          kind;   // 0 register read, 1 irq, 2 row lines
    logic [5:0]  addr;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic clk, rst_n, reg_wr;
  logic [5:0] drv_addr, mon_addr, bus_addr;
  logic mon_active;
  logic [31:0] reg_wdata, reg_rdata;
  logic [NROW-1:0] row_drive_n;
  logic [NCOL-1:0] col_in_n;
  logic irq;
  logic [15:0] keys [NROW];
  item_t sbq[$];
  int checks, errors;
  bit finished;

  assign bus_addr = mon_active ? mon_addr : drv_addr;

  kp_scanner #(.NROW(NROW), .NCOL(NCOL), .ADDR_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(bus_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .row_drive_n(row_drive_n),
    .col_in_n(col_in_n), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // key matrix model: a closed key pulls its column low when its row is driven
  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      col_in_n[c] = 1'b1;
      for (int r = 0; r < NROW; r++)
        if (keys[r][c] && !row_drive_n[r]) col_in_n[c] = 1'b0;
    end
  end

  // monitor: pops expected items and compares against the ports
  initial begin
    mon_active = 1'b0;
    mon_addr = '0;
    forever begin
      wait (sbq.size() > 0);
      begin
        item_t it;
        logic [31:0] act;
        it = sbq[0];
        @(negedge clk);
        mon_active = 1'b1;
        mon_addr = it.addr;
        #1;
        case (it.kind)
          0: act = reg_rdata;
          1: act = {31'd0, irq};
          default: act = {16'd0, row_drive_n};
        endcase
        mon_active = 1'b0;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
        void'(sbq.pop_front());
      end
    end
  end

  task automatic expect_item(int kind, logic [5:0] a, logic [31:0] e, string req);
    item_t it;
    it.kind = kind; it.addr = a; it.exp = e; it.req = req;
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    drv_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_val(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    checks = 0; errors = 0; finished = 1'b0;
    reg_wr = 1'b0; drv_addr = '0; reg_wdata = '0;
    for (int r = 0; r < NROW; r++) keys[r] = '0;
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    expect_item(0, 6'h00, 32'h0, "R1 ctrl");
    expect_item(0, 6'h08, 32'h0, "R1 status");
    expect_item(0, 6'h0C, 32'h0, "R1 mask");
    expect_item(1, 6'h00, 32'h0, "R1 irq");
    expect_item(2, 6'h00, 32'h0000FFFF, "R1 rows");
    expect_item(0, 6'h10, 32'hFFFFFFFF, "R1 data");

    // R4 single scan of all rows
    keys[0] = 16'h0008; keys[5] = 16'h0001; keys[9] = 16'h1000;
    wr(6'h04, 32'h0000_1010);
    wr(6'h00, 32'h0000_000A);          // mode 2, row delay 2
    wait_cyc(70);
    expect_item(0, 6'h00, 32'h0000_0008, "R4 mode self-clear");
    expect_item(0, 6'h10, 32'hFFFF_FFF7, "R4 row0");
    expect_item(0, 6'h18, 32'hFFFE_FFFF, "R4 row5");
    expect_item(0, 6'h20, 32'hEFFF_FFFF, "R4 row9");
    expect_item(0, 6'h08, 32'h3, "R10 done+changed");
    expect_item(1, 6'h00, 32'h0, "R11 masked off");

    // R11 mask and acknowledge
    wr(6'h0C, 32'h1);
    expect_item(1, 6'h00, 32'h1, "R11 irq on");
    wr(6'h08, 32'h3);
    expect_item(0, 6'h08, 32'h0, "R11 ack");
    expect_item(1, 6'h00, 32'h0, "R11 irq off");

    // R10 rescan, same keys: no change flag
    wr(6'h00, 32'h0000_000A);
    wait_cyc(70);
    expect_item(0, 6'h08, 32'h1, "R10 no change");

    // R9 columns beyond count read 1
    wr(6'h08, 32'h7);
    wr(6'h04, 32'h0000_0810);
    wr(6'h00, 32'h0000_000A);
    wait_cyc(70);
    expect_item(0, 6'h20, 32'hFFFF_FFFF, "R9 row9 col12 masked");
    expect_item(0, 6'h10, 32'hFFFF_FFF7, "R9 row0");
    expect_item(0, 6'h08, 32'h3, "R9 change flagged");

    // R8 rows beyond count keep contents
    keys[0] = '0; keys[5] = '0; keys[9] = 16'h0001;
    wr(6'h08, 32'h7);
    wr(6'h04, 32'h0000_1004);
    wr(6'h00, 32'h0000_000A);
    wait_cyc(40);
    expect_item(0, 6'h10, 32'hFFFF_FFFF, "R8 row0 rescanned");
    expect_item(0, 6'h18, 32'hFFFE_FFFF, "R8 row5 kept");
    expect_item(0, 6'h20, 32'hFFFF_FFFF, "R8 row9 kept");

    // R2 idle
    keys[9] = '0; keys[3] = 16'h0004;
    wr(6'h04, 32'h0000_1010);
    wr(6'h00, 32'h0);
    wait_cyc(40);
    expect_item(2, 6'h00, 32'h0000FFFF, "R2 rows high");
    expect_item(0, 6'h14, 32'hFFFF_FFFF, "R2 data untouched");
    keys[3] = '0;

    // R3 any-key, set beats acknowledge while held
    wr(6'h08, 32'h7);
    wr(6'h00, 32'h1);
    expect_item(2, 6'h00, 32'h0, "R3 rows low");
    expect_item(0, 6'h08, 32'h0, "R3 no key");
    keys[2] = 16'h0002;
    wait_cyc(3);
    expect_item(0, 6'h08, 32'h4, "R3 key flag");
    wr(6'h0C, 32'h4);
    expect_item(1, 6'h00, 32'h1, "R11 key irq");
    wr(6'h08, 32'h4);
    expect_item(0, 6'h08, 32'h4, "R3 ack ignored while held");
    expect_item(0, 6'h14, 32'hFFFF_FFFF, "R3 data untouched");
    keys[2] = '0;
    wait_cyc(2);
    wr(6'h08, 32'h4);
    expect_item(0, 6'h08, 32'h0, "R3 cleared after release");

    // R6 row delay: row0 low for 6 cycles with delay 5
    wr(6'h0C, 32'h0);
    wr(6'h04, 32'h0000_1002);
    wr(6'h00, 32'h0000_0016);
    while (row_drive_n[0]) @(negedge clk);
    n = 0;
    while (!row_drive_n[0]) begin n++; @(negedge clk); end
    check_val(n, 6, "R6 row0 low cycles");
    expect_item(2, 6'h00, 32'h0000FFFD, "R6 row1 alone low");
    wait_cyc(20);

    // R7 gap and R5 continuous scan
    wr(6'h04, 32'h0000_1001);
    wr(6'h00, 32'h0007_0003);
    while (row_drive_n[0]) @(negedge clk);
    while (!row_drive_n[0]) @(negedge clk);
    n = 0;
    while (row_drive_n[0]) begin n++; @(negedge clk); end
    check_val(n, 8, "R7 gap high cycles");
    keys[0] = 16'h0020;
    wait_cyc(30);
    expect_item(0, 6'h10, 32'hFFFF_FFDF, "R5 rescan picks key");
    expect_item(0, 6'h00, 32'h0007_0003, "R5 mode held");
    wr(6'h00, 32'h0);
    wait_cyc(5);
    finish_run();
  end
endmodule